// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This block sits on the host side of a NOR-style flash. After software has issued the last command write of a word program or an erase, it pulses a start request. The request carries four things: the word address, the data that was written, an operation type (program or erase) and a detection mode. The poller then reads that address again and again through a simple synchronous read port. It decides from the status bits in the returned words when the internal operation has finished.

Two completion signals are supported, alone or together. The first is the alternating status bit (bit 6): it flips on every read while the flash is busy and stops flipping when the flash is finished. The second is the data-polling bit (bit 7). During a program it reads inverted, and during an erase it reads 0, until the operation ends. Completion can coincide with a status read, and the rest of the word may still be settling. For this reason, once completion is seen the poller waits a fixed settle interval and then makes two confirming reads of the full word. It pulses done and sets a sticky error flag when a confirming read mismatches or when the poll budget runs out.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, done_o, err_o and rd_req_o are all 0.
- R2: Every read of an operation, both status and confirming reads, uses the address captured with the accepted start request.
- R3: In alternating-bit mode (mode_i 2'b00 or 2'b01), a status read completes the wait only when its bit 6 equals bit 6 of the status read just before it. The first status read therefore never completes the wait.
- R4: In data-polling mode (mode_i 2'b10), a status read completes the wait when its bit 7 equals the expected bit 7. The expected bit 7 is data_i bit 7 for a program (op_erase_i=0) and 1 for an erase (op_erase_i=1).
- R5: In combined mode (mode_i 2'b11), a single status read must meet both the R3 and the R4 condition to complete the wait.
- R6: Once the wait completes, no read is issued for at least SETTLE_CYC cycles. After that, exactly two confirming reads are made and the operation ends.
- R7: The operation ends without error only if both confirming reads equal the expected word. The expected word is data_i for a program and all ones for an erase. Otherwise err_o is set.
- R8: The operation ends with err_o set, and without confirming reads, once the number of status reads that did not complete the wait reaches max_polls_i. A max_polls_i of 0 acts as 1.
- R9: done_o is a one-cycle pulse at the end of each operation. err_o holds its value until the cycle after the next accepted start, where it becomes 0.
- R10: A start request that arrives while an operation is in progress is ignored. It causes no extra done pulse and no change of address, and no read is issued while the block is idle.
- R11: At most one read is outstanding. rd_req_o is not raised again until rd_valid_i has returned the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_i | input | 2 | 00/01 alternating bit, 10 data polling, 11 both |
| addr_i | input | AW | Word address to poll |
| data_i | input | DW | Data written by the program |
| max_polls_i | input | CW | Status-read budget |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Sticky failure flag |

## Verification
The hardest condition to reach is the window just after the flash finishes. In that window bit 7 already shows the final value while the other bits are still wrong. A poller that compared the full word at once would fail, and one that skipped the settle interval would also fail. The bench memory model is timed in cycles from the start request: it has a busy phase with an alternating bit 6 and a masked bit 7, then a short stale phase that returns inverted low bits, then the final word. The stale phase is shorter than the settle interval. Separate cases set the final word wrong on purpose, to prove that the confirming reads really compare.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_SETTLE,
      ST_CISSUE,
      ST_CWAIT
   } fdp_state_e;

   typedef enum logic [1:0] {
      MODE_ALT0 = 2'b00,
      MODE_ALT  = 2'b01,
      MODE_POLL = 2'b10,
      MODE_BOTH = 2'b11
   } fdp_mode_e;

endpackage

// File: rtl/fdp_count.sv
module fdp_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 1) begin : g_bad
         $error("fdp_count: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != TOP)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fdp_detect.sv
module fdp_detect
   import fdp_pkg::*;
#(
   parameter int DW       = 16,
   parameter int TOG_BIT  = 6,
   parameter int POLL_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          sample,
   input  logic [DW-1:0] word,
   input  logic [1:0]    mode,
   input  logic          exp_bit,
   output logic          hit
);
   logic prev_q;
   logic have_q;
   logic hit_alt;
   logic hit_poll;

   generate
      if (TOG_BIT >= DW || POLL_BIT >= DW) begin : g_bad
         $error("fdp_detect: status bit outside word");
      end
      if (TOG_BIT == POLL_BIT) begin : g_same
         $error("fdp_detect: status bits must differ");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         have_q <= 1'b0;
      end else if (clr) begin
         have_q <= 1'b0;
      end else if (sample) begin
         prev_q <= word[TOG_BIT];
         have_q <= 1'b1;
      end
   end

   always_comb begin
      hit_alt  = have_q && (word[TOG_BIT] == prev_q);
      hit_poll = (word[POLL_BIT] == exp_bit);
      case (fdp_mode_e'(mode))
         MODE_POLL: hit = hit_poll;
         MODE_BOTH: hit = hit_alt && hit_poll;
         default:   hit = hit_alt;
      endcase
   end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
   import fdp_pkg::*;
#(
   parameter int DW         = 16,
   parameter int AW         = 18,
   parameter int CW         = 16,
   parameter int SETTLE_CYC = 125,
   parameter int TOG_BIT    = 6,
   parameter int POLL_BIT   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          op_erase_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   input  logic [CW-1:0] max_polls_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_valid_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          done_o,
   output logic          err_o
);
   localparam int SW = $clog2(SETTLE_CYC + 1);
   localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("flash_done_poller: SETTLE_CYC must be at least 1");
      end
      if (DW < 8 || AW < 1 || CW < 1) begin : g_bad_width
         $error("flash_done_poller: width parameter too small");
      end
   endgenerate

   fdp_state_e    st_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] exp_q;
   logic [1:0]    mode_q;
   logic [CW-1:0] max_q;
   logic          conf_idx_q;
   logic          conf_ok_q;
   logic          done_q;
   logic          err_q;

   logic          accept;
   logic          stat_sample;
   logic          hit;
   logic [CW-1:0] poll_cnt;
   logic [SW-1:0] set_cnt;
   logic          limit_hit;
   logic          word_ok;

   assign accept      = start_i && (st_q == ST_IDLE);
   assign stat_sample = (st_q == ST_WAIT) && rd_valid_i;
   assign word_ok     = (rd_data_i == exp_q);
   assign limit_hit   = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, max_q};

   fdp_detect #(
      .DW(DW), .TOG_BIT(TOG_BIT), .POLL_BIT(POLL_BIT)
   ) u_det (
      .clk(clk), .rst_n(rst_n), .clr(accept), .sample(stat_sample),
      .word(rd_data_i), .mode(mode_q), .exp_bit(exp_q[POLL_BIT]), .hit(hit)
   );

   fdp_count #(.W(CW)) u_polls (
      .clk(clk), .rst_n(rst_n), .clr(accept),
      .inc(stat_sample && !hit), .cnt(poll_cnt)
   );

   fdp_count #(.W(SW)) u_settle (
      .clk(clk), .rst_n(rst_n), .clr(st_q != ST_SETTLE),
      .inc(st_q == ST_SETTLE), .cnt(set_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         exp_q      <= '0;
         mode_q     <= '0;
         max_q      <= '0;
         conf_idx_q <= 1'b0;
         conf_ok_q  <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  addr_q <= addr_i;
                  exp_q  <= op_erase_i ? {DW{1'b1}} : data_i;
                  mode_q <= mode_i;
                  max_q  <= max_polls_i;
                  err_q  <= 1'b0;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (rd_valid_i) begin
                  if (hit) begin
                     st_q <= ST_SETTLE;
                  end else if (limit_hit) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            ST_SETTLE: begin
               if (set_cnt == SETTLE_LAST) begin
                  conf_idx_q <= 1'b0;
                  conf_ok_q  <= 1'b1;
                  st_q       <= ST_CISSUE;
               end
            end
            ST_CISSUE: st_q <= ST_CWAIT;
            ST_CWAIT: begin
               if (rd_valid_i) begin
                  if (conf_idx_q) begin
                     done_q <= 1'b1;
                     err_q  <= !(conf_ok_q && word_ok);
                     st_q   <= ST_IDLE;
                  end else begin
                     conf_idx_q <= 1'b1;
                     conf_ok_q  <= conf_ok_q && word_ok;
                     st_q       <= ST_CISSUE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_req_o  = (st_q == ST_ISSUE) || (st_q == ST_CISSUE);
   assign rd_addr_o = addr_q;
   assign done_o    = done_q;
   assign err_o     = err_q;
endmodule

// File: rtl/fdp_poller_chk.sv
module fdp_poller_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic rd_req_o,
   input logic rd_valid_i,
   input logic done_o,
   input logic err_o
);
   logic pend_q;
   logic busy_q;
   logic take;

   assign take = start_i && (!busy_q || done_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (rd_req_o) pend_q <= 1'b1;
         else if (rd_valid_i) pend_q <= 1'b0;
         if (take) busy_q <= 1'b1;
         else if (done_o) busy_q <= 1'b0;
      end
   end

   // R11
   one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q && rd_req_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !err_o);

   // R10
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_q);

   // R8
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);
endmodule

bind flash_done_poller fdp_poller_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
   .rd_valid_i(rd_valid_i), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
   localparam int DW = 16;
   localparam int AW = 18;
   localparam int CW = 16;
   localparam int SETTLE = 8;
   localparam int STALE = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_erase_i = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] data_i = '0;
   logic [CW-1:0] max_polls_i = '0;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_valid_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          done_o;
   logic          err_o;

   flash_done_poller #(.DW(DW), .AW(AW), .CW(CW), .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .mode_i(mode_i), .addr_i(addr_i), .data_i(data_i),
      .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o),
      .err_o(err_o)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit wd_expired = 1'b0;
   int dones = 0;

   // memory model state
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_exp;
   logic [DW-1:0] m_final;
   bit            m_erase;
   int            m_busy_end = 0;
   logic          tog = 1'b0;
   int            reads = 0;
   int            tail = 0;
   int            last_req = 0;
   int            addr_bad = 0;

   typedef struct {
      string tag;
      bit    xerr;
      int    xreads;
      int    xtail;
   } exp_t;
   exp_t q[$];

   task automatic check(input bit ok, input string req, input int act, input int xp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, xp);
      end
   endtask

   function automatic logic [DW-1:0] model_word();
      logic [DW-1:0] w;
      if (cyc < m_busy_end) begin
         w = 16'h5A3C;
         w[6] = tog;
         w[7] = m_erase ? 1'b0 : ~m_exp[7];
      end else if (cyc < m_busy_end + STALE) begin
         w = ~m_final;
         w[6] = m_final[6];
         w[7] = m_final[7];
      end else begin
         w = m_final;
      end
      return w;
   endfunction

   always @(posedge clk) begin
      cyc++;
      rd_valid_i <= 1'b0;
      if (rd_req_o) begin
         rd_valid_i <= 1'b1;
         rd_data_i  <= model_word();
         if (cyc < m_busy_end) tog <= ~tog;
         if (rd_addr_o != m_addr) addr_bad++;
         if (reads > 0 && (cyc - last_req) >= SETTLE) tail = 1;
         else tail++;
         last_req = cyc;
         reads++;
      end
   end

   // scoreboard monitor
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (done_o && prev_done)
         check(1'b0, "R9 done wider than one cycle", 2, 1);
      if (done_o) begin
         dones++;
         if (q.size() == 0) begin
            check(1'b0, "R10 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(err_o == e.xerr, {e.tag, " err_o"}, err_o, e.xerr);
            check(addr_bad == 0, {"R2 ", e.tag, " wrong read address"}, addr_bad, 0);
            if (e.xreads >= 0)
               check(reads == e.xreads, {e.tag, " read count"}, reads, e.xreads);
            if (e.xtail >= 0)
               check(tail == e.xtail, {"R6 ", e.tag, " reads after settle gap"}, tail, e.xtail);
         end
      end
      prev_done = done_o;
   end

   task automatic run_case(input string tag, input logic [1:0] mode, input bit erase,
                           input int addr, input int data, input int maxp, input int busy,
                           input int fin, input bit xerr, input int xreads, input int xtail,
                           input bit restart);
      exp_t e;
      e.tag = tag; e.xerr = xerr; e.xreads = xreads; e.xtail = xtail;
      q.push_back(e);
      @(negedge clk);
      m_addr = AW'(addr);
      m_erase = erase;
      m_exp = erase ? 16'hFFFF : DW'(data);
      m_final = DW'(fin);
      m_busy_end = cyc + busy;
      reads = 0; tail = 0; addr_bad = 0; tog = 1'b0;
      start_i = 1'b1; mode_i = mode; op_erase_i = erase;
      addr_i = AW'(addr); data_i = DW'(data); max_polls_i = CW'(maxp);
      @(negedge clk);
      start_i = 1'b0;
      check(err_o == 1'b0, {"R9 ", tag, " err cleared after start"}, err_o, 0);
      if (restart) begin
         repeat (5) @(negedge clk);
         start_i = 1'b1; addr_i = AW'(addr ^ 'h3F); op_erase_i = ~erase;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait (q.size() == 0 || wd_expired);
      repeat (30) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(done_o == 1'b0, "R1 done_o at reset", done_o, 0);
      check(err_o == 1'b0, "R1 err_o at reset", err_o, 0);
      check(rd_req_o == 1'b0, "R1 rd_req_o at reset", rd_req_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 alternating bit, program, success
      run_case("R3 alt program", 2'b01, 0, 'h12345, 'hA5C3, 100, 30, 'hA5C3, 0, -1, 2, 0);
      // R3 flash already finished: second status read completes, then two confirms
      run_case("R3 alt first read", 2'b01, 0, 'h00100, 'h1234, 100, 0, 'h1234, 0, 4, 2, 0);
      // R4 data polling, program, success
      run_case("R4 poll program", 2'b10, 0, 'h2AAAA, 'h3C81, 100, 25, 'h3C81, 0, -1, 2, 0);
      // R4 finished flash: first status read completes
      run_case("R4 poll first read", 2'b10, 0, 'h00200, 'h0F00, 100, 0, 'h0F00, 0, 3, 2, 0);
      // R4 erase polling
      run_case("R4 poll erase", 2'b10, 1, 'h15555, 'h0000, 100, 40, 'hFFFF, 0, -1, 2, 0);
      // R5 combined, erase
      run_case("R5 both erase", 2'b11, 1, 'h00777, 'h0000, 100, 40, 'hFFFF, 0, -1, 2, 0);
      // R7 program leaves a wrong low bit
      run_case("R7 poll bad word", 2'b10, 0, 'h01234, 'h3C81, 100, 20, 'h3C85, 1, -1, 2, 0);
      // R7 erase leaves one bit cleared
      run_case("R7 alt bad erase", 2'b01, 1, 'h03000, 'h0000, 100, 20, 'hFFEF, 1, -1, 2, 0);
      // R8 budget exhausted
      run_case("R8 alt timeout", 2'b00, 0, 'h04000, 'h5555, 6, 10000, 'h5555, 1, 6, -1, 0);
      // R9 err stays set while idle
      check(err_o == 1'b1, "R9 err_o sticky while idle", err_o, 1);
      // R8 zero budget acts as one
      run_case("R8 zero budget", 2'b10, 1, 'h05000, 'h0000, 0, 10000, 'hFFFF, 1, 1, -1, 0);
      // R10 second start during operation ignored
      run_case("R10 restart ignored", 2'b11, 0, 'h06000, 'h8001, 100, 30, 'h8001, 0, -1, 2, 1);
      check(dones == 11, "R10 total done pulses", dones, 11);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      wd_expired = 1'b1;
      check(1'b0, "watchdog R9 done never seen", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule